// File: doc/BRIEF.md
# System Control Port Register

A one-byte control register that sits at a single address on a byte-wide I/O bus. Software writes it to open or close a fast gate for address line 20 and to request a system reset. Every write stores the whole byte, and in the same access it updates the gate level and, when the request bit is set, fires a reset request. Reads give back the byte exactly as it was last written.

Two reset inputs act on the register, and they behave differently. The chip reset `rst` returns everything to zero. The device reset `dev_rst` clears only the reset-request bit, so the gate setting survives it. The request output is a one-clock pulse tied to the write access, not a level that follows the stored bit. Because of that, clearing the stored bit never starts or stops a request.

Top module: `sysctl_port`

## Requirements
- R1: The register responds only at I/O address 0x0092, and all address bits are decoded. A write to any other address leaves the register, the gate and the request output unchanged. A read of any other address gives `io_rvalid`=0 and `io_rdata`=0x00 in the following cycle.
- R2: A write at 0x0092 stores all 8 data bits unchanged. A read at 0x0092 raises `io_rvalid` for one cycle in the cycle after the strobe, with `io_rdata` equal to the stored byte, bit 0 included.
- R3: `a20_gate` equals bit 1 of the most recently written byte. It changes at the clock edge that samples the write strobe.
- R4: A write at 0x0092 with data bit 0 set drives `rst_req` high for exactly the one cycle after the write edge. A write with bit 0 clear, and any cycle without a write, leaves `rst_req` low. Back-to-back such writes give one pulse per write.
- R5: `dev_rst` with no write in the same cycle clears only bit 0 of the stored byte. `a20_gate` and the other bits are kept, and no request pulse is produced.
- R6: While `rst` is high the stored byte is 0x00, and `a20_gate`, `rst_req`, `io_rvalid` and `io_rdata` are all 0.
- R7: When `dev_rst` and a write at 0x0092 fall in the same cycle, the write wins. The full byte is stored, the gate follows its bit 1, and its bit 0 still fires a pulse.
- R8: When a read and a write at 0x0092 fall in the same cycle, the read returns the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset, clears the register |
| dev_rst | input | 1 | Synchronous device reset, clears only the request bit |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0x00 unless a hit read returns |
| io_rvalid | output | 1 | High for one cycle when io_rdata carries a hit read |
| a20_gate | output | 1 | Registered address-line-20 gate level |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
A device reset and a write can land on the same clock edge and pull the stored request bit in opposite directions. A read and a write can also share an edge and race for the byte. The bench drives `dev_rst` together with a write of 0x81. It expects the byte to be stored whole, the gate to go low and the pulse to fire, and it then reads the byte back to confirm bit 0 survived. It also issues a read and a write of 0x06 in one cycle, expects the earlier byte, and then reads again to confirm the new byte was stored.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned IO_ADDR_W = 16;
  localparam int unsigned IO_DATA_W = 8;
  localparam logic [IO_ADDR_W-1:0] CTL_PORT_ADDR = 16'h0092;
  localparam int unsigned GATE_BIT = 1;
  localparam int unsigned REQ_BIT  = 0;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } port_hit_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W = sysctl_pkg::IO_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE = sysctl_pkg::CTL_PORT_ADDR
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output sysctl_pkg::port_hit_t hit
);
  logic match;
  // Full decode: every address bit takes part in the match.
  assign match      = (addr == BASE);
  assign hit.wr_hit = wr & match;
  assign hit.rd_hit = rd & match;
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned DATA_W   = sysctl_pkg::IO_DATA_W,
  parameter int unsigned GATE_POS = sysctl_pkg::GATE_BIT,
  parameter int unsigned REQ_POS  = sysctl_pkg::REQ_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic              gate_q
);
  localparam logic [DATA_W-1:0] REQ_MASK  = DATA_W'(1) << REQ_POS;
  localparam logic [DATA_W-1:0] KEEP_MASK = ~REQ_MASK;

  // A write takes priority over the device reset (R7).
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_hit) begin
      ctl_q <= wdata;
    end else if (dev_rst) begin
      ctl_q <= ctl_q & KEEP_MASK;
    end
  end

  // The gate output has its own flop and is only loaded by writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
    end else if (wr_hit) begin
      gate_q <= wdata[GATE_POS];
    end
  end

  p_wr_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ctl_q == $past(wdata));
  p_devrst_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (dev_rst && !wr_hit) |=> (ctl_q == ($past(ctl_q) & KEEP_MASK)) && $stable(gate_q));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !dev_rst) |=> $stable(ctl_q) && $stable(gate_q));
  p_gate_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    gate_q == ctl_q[GATE_POS]);
endmodule

// File: rtl/sysctl_pulse.sv
module sysctl_pulse (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic req_bit,
  output logic pulse_q
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      // The pulse comes from the write itself, not from the stored bit.
      pulse_q <= wr_hit & req_bit;
      past_ok <= 1'b1;
    end
  end

  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && pulse_q) |-> $past(wr_hit && req_bit));
  p_pulse_absent_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && req_bit) |=> !pulse_q);
endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport #(
  parameter int unsigned DATA_W = sysctl_pkg::IO_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
      rdata_q  <= rd_hit ? ctl_q : '0;
    end
  end

  p_rd_miss_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> !rvalid_q && (rdata_q == '0));
  p_rd_old_r8: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rvalid_q && (rdata_q == $past(ctl_q)));
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port #(
  parameter int unsigned ADDR_W = sysctl_pkg::IO_ADDR_W,
  parameter int unsigned DATA_W = sysctl_pkg::IO_DATA_W,
  parameter logic [ADDR_W-1:0] PORT_ADDR = sysctl_pkg::CTL_PORT_ADDR,
  parameter int unsigned GATE_POS = sysctl_pkg::GATE_BIT,
  parameter int unsigned REQ_POS  = sysctl_pkg::REQ_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              a20_gate,
  output logic              rst_req
);
  sysctl_pkg::port_hit_t hit;
  logic [DATA_W-1:0]     ctl_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .BASE(PORT_ADDR)) u_decode (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .hit(hit)
  );

  sysctl_store #(.DATA_W(DATA_W), .GATE_POS(GATE_POS), .REQ_POS(REQ_POS)) u_store (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .wr_hit(hit.wr_hit),
    .wdata(io_wdata), .ctl_q(ctl_q), .gate_q(a20_gate)
  );

  sysctl_pulse u_pulse (
    .clk(clk), .rst(rst), .wr_hit(hit.wr_hit),
    .req_bit(io_wdata[REQ_POS]), .pulse_q(rst_req)
  );

  sysctl_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk(clk), .rst(rst), .rd_hit(hit.rd_hit), .ctl_q(ctl_q),
    .rdata_q(io_rdata), .rvalid_q(io_rvalid)
  );

  // R7: a write that meets a device reset still stores its bit 0 and still pulses.
  p_wr_beats_devrst_r7: assert property (@(posedge clk) disable iff (rst)
    (dev_rst && io_wr && io_addr == PORT_ADDR && io_wdata[REQ_POS])
      |=> rst_req && ctl_q[REQ_POS]);
endmodule

// File: tb/sysctl_port_test.sv
module sysctl_port_test;
  logic        clk = 1'b0;
  logic        rst, dev_rst, io_wr, io_rd;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_rvalid, a20_gate, rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sysctl_port uut (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .a20_gate(a20_gate), .rst_req(rst_req)
  );

  // Fields: wr rd drst addr[16] wdata[8] exp_a20 exp_pulse exp_rvalid exp_rdata[8] pad[2]
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,16'h0092,8'h02, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R3 gate opens
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b1,1'b0,1'b1,8'h02, 2'b0}, // R2 read back
    {1'b1,1'b0,1'b0,16'h0093,8'hFF, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R1 miss write
    {1'b0,1'b1,1'b0,16'h0093,8'h00, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R1 miss read
    {1'b1,1'b0,1'b0,16'h0092,8'hA5, 1'b0,1'b1,1'b0,8'h00, 2'b0}, // R4 pulse, gate closes
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b0,1'b0,1'b1,8'hA5, 2'b0}, // R2 bit0 read back, pulse ended
    {1'b0,1'b0,1'b1,16'h0000,8'h00, 1'b0,1'b0,1'b0,8'h00, 2'b0}, // R5 device reset
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b0,1'b0,1'b1,8'hA4, 2'b0}, // R5 only bit0 cleared
    {1'b1,1'b0,1'b0,16'h0092,8'h03, 1'b1,1'b1,1'b0,8'h00, 2'b0}, // R4 first pulse
    {1'b1,1'b0,1'b0,16'h0092,8'h03, 1'b1,1'b1,1'b0,8'h00, 2'b0}, // R4 back-to-back pulse
    {1'b0,1'b0,1'b1,16'h0000,8'h00, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R5 gate kept
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b1,1'b0,1'b1,8'h02, 2'b0}, // R5 read 0x02
    {1'b1,1'b0,1'b0,16'h1092,8'h00, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R1 upper bits differ
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b1,1'b0,1'b1,8'h02, 2'b0}, // R1 unchanged
    {1'b1,1'b0,1'b0,16'h0092,8'h7E, 1'b1,1'b0,1'b0,8'h00, 2'b0}, // R4 bit0 clear, no pulse
    {1'b0,1'b1,1'b0,16'h0092,8'h00, 1'b1,1'b0,1'b1,8'h7E, 2'b0}  // R2 all bits stored
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge; after the next rising edge, sample at the following falling edge.
  task automatic step(input logic w, input logic r, input logic d,
                      input logic [15:0] a, input logic [7:0] dat);
    io_wr = w; io_rd = r; dev_rst = d; io_addr = a; io_wdata = dat;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; dev_rst = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic check_all(input string tag, input logic a20, input logic pl,
                           input logic rv, input logic [7:0] rd);
    chk({tag, " R3 a20_gate"}, {7'd0, a20_gate}, {7'd0, a20});
    chk({tag, " R4 rst_req"}, {7'd0, rst_req}, {7'd0, pl});
    chk({tag, " R2/R1 io_rvalid"}, {7'd0, io_rvalid}, {7'd0, rv});
    chk({tag, " R2/R1 io_rdata"}, io_rdata, rd);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; dev_rst = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
    io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    check_all("R6 reset state", 1'b0, 1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b0, 16'h0092, 8'h00);
    check_all("R6 byte after reset", 1'b0, 1'b0, 1'b1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      step(v[39], v[38], v[37], v[36:21], v[20:13]);
      check_all($sformatf("vec%0d", i), v[12], v[11], v[10], v[9:2]);
    end

    // R7: device reset and write in the same cycle; the write wins.
    step(1'b1, 1'b0, 1'b1, 16'h0092, 8'h81);
    check_all("R7 collide", 1'b0, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b0, 16'h0092, 8'h00);
    check_all("R7 readback", 1'b0, 1'b0, 1'b1, 8'h81);

    // R8: read and write in one cycle return the earlier byte.
    step(1'b1, 1'b1, 1'b0, 16'h0092, 8'h06);
    check_all("R8 same-cycle read", 1'b1, 1'b0, 1'b1, 8'h81);
    step(1'b0, 1'b1, 1'b0, 16'h0092, 8'h00);
    check_all("R8 new byte", 1'b1, 1'b0, 1'b1, 8'h06);

    // R6: chip reset mid-run clears the gate and the byte.
    rst = 1'b1;
    @(negedge clk);
    check_all("R6 mid-run reset", 1'b0, 1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b0, 16'h0092, 8'h00);
    check_all("R6 cleared byte", 1'b0, 1'b0, 1'b1, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule